// File: doc/BRIEF.md
# Four-Wide Instruction Group Former

This block sits behind the head of an instruction buffer and looks at up to four decoded entries each cycle. It walks the entries in program order and builds the largest group that can go out together without breaking any slot, unit or register-write restriction. For each entry that joins, it names the execution unit that takes it. The walk stops at the first entry that cannot join, so issue stays in order.

Each lane carries a valid bit and a 4-bit class code. The result is registered: the count and unit map for the entries presented in one cycle appear on the outputs after the next rising clock edge. The buffer uses the count to decide how many entries to pop.

Class codes: 0 generic integer, 1 shift (unit 0 only), 2 condition-code setter (unit 1 only, writes no integer register), 3 load, 4 store, 5 branch, 6 FP multiply-class, 7 FP add-class, 8 single-issue, 9 jump-and-link or call. Codes 10 to 15 are reserved. Unit codes: 0 none, 1 integer ALU 0, 2 integer ALU 1, 3 memory port, 4 branch unit, 5 FP multiply pipe, 6 FP add pipe.

Top module: `issue_group_former`

## Requirements
- R1: The outputs are registered with one cycle of latency and read zero after reset. grp_cnt equals the number of leading lanes that join the group. Lane i of grp_unit (bits 3i+2..3i) is non-zero exactly when i < grp_cnt.
- R2: A lane whose valid bit is low, or whose class is a reserved code (10 to 15), ends the group without issuing, and so do all lanes after it.
- R3: A generic integer entry (class 0) takes ALU 0 (unit 1) if it is free and otherwise ALU 1 (unit 2). No group uses either ALU more than once.
- R4: A shift entry (class 1) can use only ALU 0. If ALU 0 is already taken, the group stops at that entry.
- R5: A condition-code setter (class 2) and a jump-and-link (class 9) can use only ALU 1. If ALU 1 is already taken, the group stops at that entry.
- R6: A group holds at most one load or store (unit 3), one branch (unit 4), one FP multiply (unit 5) and one FP add (unit 6).
- R7: A single-issue entry (class 8) issues only from lane 0, alone, on ALU 0. In any later lane it stops the group.
- R8: A jump-and-link also claims the memory port, so it cannot join a group that already holds a load or store. It is always the last entry of its group.
- R9: A group makes at most two integer register writes (classes 0, 1, 3 and 9 write) and at most one FP register write (classes 6 and 7). An entry that would exceed either limit stops the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 4 | Valid bit per buffer lane, lane 0 oldest |
| slot_cls | input | 16 | 4-bit class code per lane, lane i at bits 4i+3..4i |
| grp_cnt | output | 3 | Number of lanes issued in the group |
| grp_unit | output | 12 | 3-bit unit code per lane, lane i at bits 3i+2..3i |

## Verification
A resource flag that stays set or is never set shows up one cycle later. The count comes out short, or two lanes name the same unit, in the very group where the lost or stale flag matters. A wrong write tally or a broken stop condition shows up at the same point: an extra lane is issued past the place where the group should have ended, or a lane after a gap carries a unit. Because the outputs are compared with a reference model after every edge, over both directed groupings and random ones, any such fault is reported in the cycle it first changes the output.

// File: rtl/issue_group_former.sv
module issue_group_former #(
  parameter int LANES = 4,
  parameter int MAX_IWR = 2,
  parameter int MAX_FWR = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       slot_vld,
  input  logic [4*LANES-1:0]     slot_cls,
  output logic [CW-1:0]          grp_cnt,
  output logic [3*LANES-1:0]     grp_unit
);
  localparam int CW = $clog2(LANES + 1);

  localparam logic [3:0] K_INT = 4'd0, K_SHF = 4'd1, K_CC = 4'd2, K_LD = 4'd3,
                         K_ST = 4'd4, K_BR = 4'd5, K_FM = 4'd6, K_FA = 4'd7,
                         K_SGL = 4'd8, K_JL = 4'd9;
  localparam logic [2:0] U_NONE = 3'd0, U_A0 = 3'd1, U_A1 = 3'd2, U_MEM = 3'd3,
                         U_BR = 3'd4, U_FM = 3'd5, U_FA = 3'd6;

  logic [CW-1:0]      cnt_n;
  logic [3*LANES-1:0] unit_n;
  logic               stop, a0, a1, mem, bru, fmu, fau, ok, endg, wi, wf;
  logic [CW-1:0]      iw, fw;
  logic [3:0]         c;
  logic [2:0]         u;

  always_comb begin
    stop = 1'b0; a0 = 1'b0; a1 = 1'b0; mem = 1'b0; bru = 1'b0; fmu = 1'b0; fau = 1'b0;
    iw = '0; fw = '0; cnt_n = '0; unit_n = '0;
    c = '0; u = U_NONE; ok = 1'b0; endg = 1'b0; wi = 1'b0; wf = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      c = slot_cls[4*i +: 4];
      ok = 1'b0; u = U_NONE; endg = 1'b0; wi = 1'b0; wf = 1'b0;
      if (!stop && slot_vld[i]) begin
        case (c)
          K_INT: begin
            wi = 1'b1;
            if (!a0) begin ok = 1'b1; u = U_A0; end
            else if (!a1) begin ok = 1'b1; u = U_A1; end
          end
          K_SHF: begin wi = 1'b1; ok = !a0; u = U_A0; end
          K_CC:  begin ok = !a1; u = U_A1; end
          K_LD:  begin wi = 1'b1; ok = !mem; u = U_MEM; end
          K_ST:  begin ok = !mem; u = U_MEM; end
          K_BR:  begin ok = !bru; u = U_BR; end
          K_FM:  begin wf = 1'b1; ok = !fmu; u = U_FM; end
          K_FA:  begin wf = 1'b1; ok = !fau; u = U_FA; end
          K_SGL: begin ok = (i == 0); u = U_A0; endg = 1'b1; end
          K_JL:  begin wi = 1'b1; ok = !a1 && !mem; u = U_A1; endg = 1'b1; end
          default: ok = 1'b0;
        endcase
        if (wi && (int'(iw) + 1 > MAX_IWR)) ok = 1'b0;
        if (wf && (int'(fw) + 1 > MAX_FWR)) ok = 1'b0;
      end
      if (!ok) stop = 1'b1;
      else begin
        unit_n[3*i +: 3] = u;
        cnt_n = cnt_n + 1'b1;
        case (u)
          U_A0: a0 = 1'b1;
          U_A1: a1 = 1'b1;
          U_MEM: mem = 1'b1;
          U_BR: bru = 1'b1;
          U_FM: fmu = 1'b1;
          U_FA: fau = 1'b1;
          default: ;
        endcase
        if (c == K_JL) mem = 1'b1;
        if (wi) iw = iw + 1'b1;
        if (wf) fw = fw + 1'b1;
        if (endg) stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_cnt  <= '0;
      grp_unit <= '0;
    end else begin
      grp_cnt  <= cnt_n;
      grp_unit <= unit_n;
    end
  end

  logic [LANES-1:0] h_a0, h_a1, h_mem, h_br, h_fp;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      h_a0[i]  = grp_unit[3*i +: 3] == U_A0;
      h_a1[i]  = grp_unit[3*i +: 3] == U_A1;
      h_mem[i] = grp_unit[3*i +: 3] == U_MEM;
      h_br[i]  = grp_unit[3*i +: 3] == U_BR;
      h_fp[i]  = (grp_unit[3*i +: 3] == U_FM) || (grp_unit[3*i +: 3] == U_FA);
    end
  end

  // R3
  alu0_once_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(h_a0));
  // R3
  alu1_once_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(h_a1));
  // R6
  mem_once_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(h_mem));
  // R6
  br_once_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(h_br));
  // R9
  fp_write_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(h_fp) <= 1);
  // R7
  single_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld[0] && slot_cls[3:0] == K_SGL) |=> (grp_cnt == 1 && grp_unit[2:0] == U_A0));
  // R8
  jl_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld[0] && slot_cls[3:0] == K_JL) |=> (grp_cnt == 1 && grp_unit[2:0] == U_A1));
  // R2
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld[0] |=> (grp_cnt == 0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R1
    lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g < int'(grp_cnt)) == (grp_unit[3*g +: 3] != U_NONE));
  end
endmodule

// File: tb/issue_group_former_tb.sv
module issue_group_former_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  slot_vld = '0;
  logic [15:0] slot_cls = '0;
  logic [2:0]  grp_cnt;
  logic [11:0] grp_unit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  issue_group_former u_dut (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_cls(slot_cls),
    .grp_cnt(grp_cnt), .grp_unit(grp_unit)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic void ref_group(input logic [3:0] v, input logic [15:0] cl,
                                    output int n, output logic [11:0] um);
    int taken[7];
    int iwr, fwr, unit_pick, writes_i, writes_f;
    bit closes;
    n = 0; um = '0; iwr = 0; fwr = 0;
    foreach (taken[k]) taken[k] = 0;
    for (int k = 0; k < 4; k++) begin
      int code;
      if (!v[k]) break;
      code = int'(cl[4*k +: 4]);
      unit_pick = 0; writes_i = 0; writes_f = 0; closes = 0;
      if (code == 0) begin writes_i = 1; unit_pick = (taken[1] == 0) ? 1 : (taken[2] == 0) ? 2 : 0; end
      else if (code == 1) begin writes_i = 1; unit_pick = (taken[1] == 0) ? 1 : 0; end
      else if (code == 2) unit_pick = (taken[2] == 0) ? 2 : 0;
      else if (code == 3 || code == 4) begin writes_i = (code == 3); unit_pick = (taken[3] == 0) ? 3 : 0; end
      else if (code == 5) unit_pick = (taken[4] == 0) ? 4 : 0;
      else if (code == 6) begin writes_f = 1; unit_pick = (taken[5] == 0) ? 5 : 0; end
      else if (code == 7) begin writes_f = 1; unit_pick = (taken[6] == 0) ? 6 : 0; end
      else if (code == 8) begin closes = 1; unit_pick = (k == 0) ? 1 : 0; end
      else if (code == 9) begin writes_i = 1; closes = 1; unit_pick = (taken[2] == 0 && taken[3] == 0) ? 2 : 0; end
      if (unit_pick == 0) break;
      if (iwr + writes_i > 2 || fwr + writes_f > 1) break;
      taken[unit_pick]++;
      if (code == 9) taken[3]++;
      iwr += writes_i; fwr += writes_f;
      um[3*k +: 3] = 3'(unit_pick);
      n++;
      if (closes) break;
    end
  endfunction

  function automatic logic [15:0] pk(input int a, input int b, input int c, input int d);
    return {4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  int          exp_n;
  logic [11:0] exp_u;
  string       exp_tag;

  task automatic check_now();
    total++;
    if (int'(grp_cnt) != exp_n || grp_unit != exp_u) begin
      bad++;
      $display("FAIL %s: cnt=%0d units=%h expected cnt=%0d units=%h",
               exp_tag, grp_cnt, grp_unit, exp_n, exp_u);
    end
  endtask

  task automatic apply(input logic [3:0] v, input logic [15:0] cl, input string tag);
    int n; logic [11:0] um;
    @(negedge clk);
    check_now();
    slot_vld = v; slot_cls = cl;
    ref_group(v, cl, n, um);
    exp_n = n; exp_u = um; exp_tag = tag;
  endtask

  initial begin
    exp_n = 0; exp_u = '0; exp_tag = "R1 reset";
    slot_vld = 4'hF; slot_cls = pk(0, 0, 5, 6);
    repeat (3) @(negedge clk);
    check_now();
    rst_n = 1'b1;
    slot_vld = '0; exp_n = 0; exp_u = '0; exp_tag = "R2 empty";
    apply(4'hF, pk(0, 0, 0, 5), "R3 third generic int stops");
    apply(4'hF, pk(2, 0, 5, 7), "R5 cc on alu1 with full group");
    apply(4'hF, pk(1, 1, 5, 6), "R4 two shifts");
    apply(4'hF, pk(0, 1, 5, 6), "R4 shift after int on alu0");
    apply(4'hF, pk(2, 9, 0, 0), "R5 cc then jump-and-link");
    apply(4'hF, pk(3, 4, 0, 0), "R6 load then store");
    apply(4'hF, pk(5, 5, 0, 0), "R6 two branches");
    apply(4'hF, pk(6, 6, 0, 0), "R6 two fp multiplies");
    apply(4'hF, pk(0, 2, 4, 6), "R6 full mixed group");
    apply(4'hF, pk(6, 7, 0, 0), "R9 fp write limit");
    apply(4'hF, pk(0, 0, 3, 5), "R9 int write limit");
    apply(4'hF, pk(1, 0, 5, 3), "R9 shift int branch load");
    apply(4'hF, pk(8, 0, 0, 0), "R7 single-issue at head");
    apply(4'hF, pk(0, 8, 0, 0), "R7 single-issue in lane 1");
    apply(4'hF, pk(9, 5, 0, 0), "R8 jump-and-link ends group");
    apply(4'hF, pk(3, 9, 0, 0), "R8 jump-and-link after load");
    apply(4'hF, pk(5, 9, 0, 0), "R8 branch then jump-and-link");
    apply(4'b1101, pk(0, 5, 0, 0), "R2 invalid lane 1");
    apply(4'h0, pk(0, 0, 0, 0), "R2 nothing valid");
    apply(4'hF, pk(0, 12, 5, 5), "R2 reserved code");
    apply(4'hF, pk(5, 7, 2, 4), "R1 branch fpadd cc store");
    for (int r = 0; r < 400; r++) begin
      logic [3:0] v;
      logic [15:0] cl;
      v = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      cl = '0;
      for (int k = 0; k < 4; k++) cl[4*k +: 4] = 4'($urandom % 11);
      apply(v, cl, "R1 random");
    end
    apply(4'h0, '0, "R2 drain");
    @(negedge clk);
    check_now();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule